// File: doc/BRIEF.md
# Configurable UART Transmit Framer

This block is the sending half of an asynchronous serial port. Bytes written into it are queued and then shifted out on a single line. Each character starts with a low start bit, carries 5 to 8 data bits least significant bit first, optionally adds a parity bit, and ends with one or two high stop bits. Word length, parity mode, stop count and a break request are all run-time inputs.

The bit clock comes from a divider with a 16-bit integer part and a 6-bit fraction in 64ths. The divider emits one tick per oversample period, and a bit lasts sixteen ticks. Bytes are held either in a small FIFO or, when the FIFO is switched off, in a single holding slot. A character only starts when the port and its transmitter are both enabled. When flow control is on, a character also waits for the active-low clear-to-send input. Busy, empty and full flags let the host pace its writes.

Top module: `stx_framer_top`

## Requirements
- R1: After reset the line `txd` is high, `tx_busy` is 0, `tx_empty` is 1 and `tx_full` is 0.
- R2: One oversample tick occurs every `div_int` clock cycles, plus one extra cycle whenever adding `div_frac` to a 6-bit accumulator carries out. A bit lasts 16 ticks. With `div_int`=3 and `div_frac`=0 a bit lasts 48 cycles; with `div_int`=2 and `div_frac`=32 it lasts 40 cycles. A `div_int` of 0 acts as 1.
- R3: A character is a low start bit followed by `word_len`+5 data bits, least significant bit first (`word_len` 0 gives 5 bits, 3 gives 8 bits). Data bits above the word length are not sent.
- R4: With `par_en`=1 and `par_stick`=0, a parity bit follows the data. With `par_even`=1 the data and parity bits together hold an even number of ones; with `par_even`=0 they hold an odd number. With `par_en`=0 no parity bit is sent and `par_even` has no effect.
- R5: With `par_en`=1 and `par_stick`=1, the parity bit is constant: 0 when `par_even`=1 and 1 when `par_even`=0.
- R6: One high stop bit ends each character, or two when `stop_two`=1.
- R7: With `fifo_en`=1 the queue holds up to DEPTH (default 8) bytes and sends them in write order. `tx_full` is set when DEPTH bytes are waiting, and a write while full is dropped.
- R8: With `fifo_en`=0 a single byte can wait. `tx_full` is set as soon as it is written, and a further write is dropped.
- R9: A character starts only while `line_en` and `tx_en` are both 1 and, if `cts_flow_en`=1, while `cts_n` is 0. Otherwise waiting bytes stay queued and the line stays idle high.
- R10: While `brk_en`=1 and no character is in progress, `txd` is held low and no new character starts. A character already in progress completes first.
- R11: `tx_busy` is 1 from the start bit through the last stop bit and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_en | input | 1 | Port enable; also runs the baud divider |
| tx_en | input | 1 | Transmitter enable |
| fifo_en | input | 1 | 1: DEPTH-entry FIFO, 0: single holding slot |
| word_len | input | 2 | Data bits minus 5 |
| par_en | input | 1 | Append a parity bit |
| par_even | input | 1 | Even parity select (stick value select when `par_stick`=1) |
| par_stick | input | 1 | Constant parity bit |
| stop_two | input | 1 | Two stop bits |
| brk_en | input | 1 | Hold the line low once idle |
| cts_flow_en | input | 1 | Gate character starts on `cts_n` |
| cts_n | input | 1 | Active-low clear to send |
| div_int | input | 16 | Integer baud divisor |
| div_frac | input | 6 | Fractional baud divisor in 64ths |
| wr_valid | input | 1 | Write strobe for one byte |
| wr_data | input | 8 | Byte to send |
| txd | output | 1 | Serial output line |
| tx_busy | output | 1 | Character in progress |
| tx_empty | output | 1 | No byte waiting |
| tx_full | output | 1 | No room for another byte |

## Verification
Some properties are checked by assertions on every cycle:
- With a divisor above one, no two ticks are adjacent.
- A write while full leaves the occupancy unchanged, and the holding slot never exceeds one entry.
- A character starts only from the enable and flow-control gate, and it starts with the line low.
- The line stays low whenever break is requested while idle.
- Empty and full are never both set.

The bench scenarios cover what needs a full character to observe. The scoreboard decodes every frame bit by bit and compares it against an independently built expected frame. This covers each word length, the parity and stick modes, and the two-stop spacing between back-to-back characters. It also covers the exact bit lengths from the fractional divider, FIFO ordering with a dropped overflow write, and break arriving in the middle of a character.

// File: rtl/stx_pkg.sv
package stx_pkg;

  localparam int unsigned OSR  = 16;
  localparam int unsigned SUBW = $clog2(OSR);

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } stx_state_e;

  // Index of the last data bit: code 0 -> 4 (5 bits) ... code 3 -> 7 (8 bits)
  function automatic logic [2:0] last_index(input logic [1:0] code);
    return {1'b1, code};
  endfunction

  // Keep only the bits that belong to the selected word length
  function automatic logic [7:0] word_mask(input logic [1:0] code);
    return 8'hFF >> (2'd3 - code);
  endfunction

  // Parity bit to send, from the masked data and the mode selects
  function automatic logic parity_bit(input logic [7:0] data,
                                      input logic [1:0] code,
                                      input logic       even_sel,
                                      input logic       stick);
    logic ones;
    ones = ^(data & word_mask(code));
    if (stick) return ~even_sel;
    return even_sel ? ones : ~ones;
  endfunction

endpackage

// File: rtl/stx_baud_gen.sv
module stx_baud_gen #(
  parameter int unsigned IW = 16,
  parameter int unsigned FW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [IW-1:0] div_int,
  input  logic [FW-1:0] div_frac,
  output logic          tick
);

  logic [IW-1:0] cnt_q;
  logic [FW-1:0] acc_q;
  logic [FW:0]   acc_sum;
  logic          frac_carry;
  logic [IW-1:0] reload;

  // Accumulate the fraction; the top bit is the carry that stretches a period
  function automatic logic [FW:0] acc_add(input logic [FW-1:0] a,
                                          input logic [FW-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  // Count to load after a tick: (divisor - 1) plus the carry, divisor 0 acts as 1
  function automatic logic [IW-1:0] next_count(input logic [IW-1:0] d,
                                               input logic          c);
    logic [IW-1:0] base;
    base = (d == '0) ? '0 : d - IW'(1);
    return base + IW'(c);
  endfunction

  assign acc_sum    = acc_add(acc_q, div_frac);
  assign frac_carry = acc_sum[FW];
  assign reload     = next_count(div_int, frac_carry);
  assign tick       = run && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else if (!run) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else if (tick) begin
      cnt_q <= reload;
      acc_q <= acc_sum[FW-1:0];
    end else begin
      cnt_q <= cnt_q - IW'(1);
    end
  end

  // R2: a divisor above one never yields ticks on adjacent cycles
  a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_int > IW'(1)) |=> !tick);

endmodule

// File: rtl/stx_txq.sv
module stx_txq #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fifo_mode,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);

  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] count_q;
  logic [CW-1:0] cap;
  logic          push_ok, pop_ok;

  // Holding mode reuses the same storage with a capacity of one
  assign cap     = fifo_mode ? CW'(DEPTH) : CW'(1);
  assign full    = (count_q >= cap);
  assign empty   = (count_q == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = mem[rp_q];

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp_q] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q    <= '0;
      rp_q    <= '0;
      count_q <= '0;
    end else begin
      if (push_ok) wp_q <= ptr_inc(wp_q);
      if (pop_ok)  rp_q <= ptr_inc(rp_q);
      case ({push_ok, pop_ok})
        2'b10:   count_q <= count_q + CW'(1);
        2'b01:   count_q <= count_q - CW'(1);
        default: count_q <= count_q;
      endcase
    end
  end

  // R7: a write while full without a read leaves the occupancy unchanged
  a_r7_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> $stable(count_q));

  // R8: the holding slot never grows past one entry
  a_r8_single_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_mode && count_q <= CW'(1)) |=> (fifo_mode || count_q <= CW'(1)));

endmodule

// File: rtl/stx_frame_fsm.sv
module stx_frame_fsm
  import stx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       can_start,
  input  logic       have_data,
  input  logic [7:0] data,
  input  logic [1:0] word_len,
  input  logic       par_en,
  input  logic       par_even,
  input  logic       par_stick,
  input  logic       stop_two,
  input  logic       brk_en,
  output logic       pop,
  output logic       txd,
  output logic       busy
);

  stx_state_e      state_q;
  logic [SUBW-1:0] sub_q;
  logic [2:0]      idx_q;
  logic [2:0]      last_q;
  logic [7:0]      shreg_q;
  logic            par_q, pen_q, two_q;
  logic            start_go;
  logic            bit_end;

  // Named events for the assertions
  assign start_go = (state_q == ST_IDLE) && tick && have_data && can_start && !brk_en;
  assign bit_end  = (state_q != ST_IDLE) && tick && (sub_q == SUBW'(OSR - 1));
  assign pop      = start_go;
  assign busy     = (state_q != ST_IDLE);

  always_comb begin
    case (state_q)
      ST_START: txd = 1'b0;
      ST_DATA:  txd = shreg_q[0];
      ST_PAR:   txd = par_q;
      ST_STOP:  txd = 1'b1;
      default:  txd = !brk_en;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sub_q   <= '0;
      idx_q   <= '0;
      last_q  <= '0;
      shreg_q <= '0;
      par_q   <= 1'b0;
      pen_q   <= 1'b0;
      two_q   <= 1'b0;
    end else if (start_go) begin
      // Frame settings are captured at the start of each character
      state_q <= ST_START;
      sub_q   <= '0;
      idx_q   <= '0;
      shreg_q <= data;
      last_q  <= last_index(word_len);
      par_q   <= parity_bit(data, word_len, par_even, par_stick);
      pen_q   <= par_en;
      two_q   <= stop_two;
    end else if ((state_q != ST_IDLE) && tick) begin
      sub_q <= sub_q + SUBW'(1);
      if (bit_end) begin
        case (state_q)
          ST_START: begin
            state_q <= ST_DATA;
            idx_q   <= '0;
          end
          ST_DATA: begin
            shreg_q <= shreg_q >> 1;
            if (idx_q == last_q) begin
              state_q <= pen_q ? ST_PAR : ST_STOP;
              idx_q   <= '0;
            end else begin
              idx_q <= idx_q + 3'd1;
            end
          end
          ST_PAR: begin
            state_q <= ST_STOP;
            idx_q   <= '0;
          end
          ST_STOP: begin
            if (two_q && idx_q == 3'd0) idx_q <= 3'd1;
            else                        state_q <= ST_IDLE;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  // R9: a character begins only after the enable and flow-control gate was open
  a_r9_gated_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(can_start));

  // R3: every character opens with the line low
  a_r3_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd);

  // R10: an idle line under break is low
  a_r10_break_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && brk_en) |-> !txd);

  // R11: no new character starts while one is in progress
  a_r11_no_pop_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !pop);

endmodule

// File: rtl/stx_framer_top.sv
module stx_framer_top #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned IW    = 16,
  parameter int unsigned FW    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_en,
  input  logic          tx_en,
  input  logic          fifo_en,
  input  logic [1:0]    word_len,
  input  logic          par_en,
  input  logic          par_even,
  input  logic          par_stick,
  input  logic          stop_two,
  input  logic          brk_en,
  input  logic          cts_flow_en,
  input  logic          cts_n,
  input  logic [IW-1:0] div_int,
  input  logic [FW-1:0] div_frac,
  input  logic          wr_valid,
  input  logic [7:0]    wr_data,
  output logic          txd,
  output logic          tx_busy,
  output logic          tx_empty,
  output logic          tx_full
);

  logic       tick;
  logic       can_start;
  logic       q_pop;
  logic [7:0] q_dout;

  assign can_start = line_en && tx_en && (!cts_flow_en || !cts_n);

  stx_baud_gen #(.IW(IW), .FW(FW)) baud_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (line_en),
    .div_int  (div_int),
    .div_frac (div_frac),
    .tick     (tick)
  );

  stx_txq #(.DEPTH(DEPTH), .W(8)) txq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .fifo_mode (fifo_en),
    .push      (wr_valid),
    .din       (wr_data),
    .pop       (q_pop),
    .dout      (q_dout),
    .empty     (tx_empty),
    .full      (tx_full)
  );

  stx_frame_fsm fsm_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .can_start (can_start),
    .have_data (!tx_empty),
    .data      (q_dout),
    .word_len  (word_len),
    .par_en    (par_en),
    .par_even  (par_even),
    .par_stick (par_stick),
    .stop_two  (stop_two),
    .brk_en    (brk_en),
    .pop       (q_pop),
    .txd       (txd),
    .busy      (tx_busy)
  );

  // R7/R8: there is always room for at least one byte, so the two flags exclude
  a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_empty && tx_full));

endmodule

// File: tb/stx_framer_top_tb_top.sv
`timescale 1ns/1ps
module stx_framer_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line_en = 1'b1, tx_en = 1'b1, fifo_en = 1'b1;
  logic [1:0]  word_len = 2'd3;
  logic        par_en = 1'b0, par_even = 1'b0, par_stick = 1'b0, stop_two = 1'b0;
  logic        brk_en = 1'b0, cts_flow_en = 1'b0, cts_n = 1'b1;
  logic [15:0] div_int = 16'd1;
  logic [5:0]  div_frac = 6'd0;
  logic        wr_valid = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic        txd, tx_busy, tx_empty, tx_full;

  int n_cmp = 0;
  int n_bad = 0;
  int bitc  = 16;
  bit done  = 1'b0;

  logic [11:0] exp_bits[$];
  int          exp_len[$];
  string       exp_req[$];

  always #5 clk = ~clk;

  stx_framer_top dut_i (
    .clk(clk), .rst_n(rst_n), .line_en(line_en), .tx_en(tx_en), .fifo_en(fifo_en),
    .word_len(word_len), .par_en(par_en), .par_even(par_even), .par_stick(par_stick),
    .stop_two(stop_two), .brk_en(brk_en), .cts_flow_en(cts_flow_en), .cts_n(cts_n),
    .div_int(div_int), .div_frac(div_frac), .wr_valid(wr_valid), .wr_data(wr_data),
    .txd(txd), .tx_busy(tx_busy), .tx_empty(tx_empty), .tx_full(tx_full)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Expected frame from the current settings, written from the requirements
  task automatic expect_frame(input logic [7:0] d, input string req);
    logic [11:0] v;
    int pos;
    int n;
    int ones;
    logic pb;
    v = '0;
    n = 5 + int'(word_len);
    ones = 0;
    v[0] = 1'b0;
    for (int i = 0; i < n; i++) begin
      v[1 + i] = d[i];
      if (d[i]) ones++;
    end
    pos = 1 + n;
    if (par_en) begin
      if (par_stick) pb = !par_even;
      else if (par_even) pb = (ones % 2 == 1);
      else pb = (ones % 2 == 0);
      v[pos] = pb;
      pos++;
    end
    v[pos] = 1'b1;
    pos++;
    if (stop_two) begin
      v[pos] = 1'b1;
      pos++;
    end
    exp_bits.push_back(v);
    exp_len.push_back(pos);
    exp_req.push_back(req);
  endtask

  // Driver: one write strobe; expected frame queued when the bench expects acceptance
  task automatic send(input logic [7:0] d, input bit accepted, input string req);
    if (accepted) expect_frame(d, req);
    @(posedge clk); #1;
    wr_valid = 1'b1;
    wr_data  = d;
    @(posedge clk); #1;
    wr_valid = 1'b0;
  endtask

  task automatic wait_idle();
    int guard;
    guard = 0;
    @(negedge clk);
    while (!(tx_empty && !tx_busy) && guard < 40000) begin
      @(negedge clk);
      guard++;
    end
    repeat (2 * bitc) @(negedge clk);
  endtask

  task automatic set_cfg(input logic [1:0] wl, input logic pe, input logic ev,
                         input logic st, input logic two);
    @(posedge clk); #1;
    word_len = wl; par_en = pe; par_even = ev; par_stick = st; stop_two = two;
  endtask

  // Monitor: decode each frame at mid-bit and compare with the scoreboard head
  initial begin
    logic prev;
    prev = 1'b1;
    forever begin
      @(negedge clk);
      if (rst_n && prev && !txd && !brk_en) begin
        if (exp_bits.size() == 0) begin
          n_cmp++;
          n_bad++;
          $display("FAIL R7: actual unexpected frame expected none");
        end else begin
          logic [11:0] ev;
          logic [11:0] got;
          int len;
          string rq;
          ev  = exp_bits.pop_front();
          len = exp_len.pop_front();
          rq  = exp_req.pop_front();
          got = '0;
          repeat (bitc / 2) @(negedge clk);
          got[0] = txd;
          for (int k = 1; k < len; k++) begin
            repeat (bitc) @(negedge clk);
            got[k] = txd;
          end
          check(rq, 32'(got), 32'(ev));
        end
        prev = txd;
      end else begin
        prev = txd;
      end
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int cnt;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 txd", 32'(txd), 32'd1);
    check("R1 busy", 32'(tx_busy), 32'd0);
    check("R1 empty", 32'(tx_empty), 32'd1);
    check("R1 full", 32'(tx_full), 32'd0);

    // R3 eight data bits, no parity
    send(8'hA5, 1, "R3 8-bit A5");
    send(8'h3C, 1, "R3 8-bit 3C");
    wait_idle();
    // R3 shorter words, upper bits not sent
    set_cfg(2'd0, 0, 0, 0, 0);
    send(8'hFF, 1, "R3 5-bit FF");
    wait_idle();
    set_cfg(2'd1, 0, 0, 0, 0);
    send(8'hEA, 1, "R3 6-bit EA");
    wait_idle();
    set_cfg(2'd2, 0, 1, 0, 0);
    send(8'hD5, 1, "R3 7-bit D5 even ignored");
    wait_idle();

    // R4 even and odd parity
    set_cfg(2'd3, 1, 1, 0, 0);
    send(8'h07, 1, "R4 even 07");
    send(8'h03, 1, "R4 even 03");
    wait_idle();
    set_cfg(2'd3, 1, 0, 0, 0);
    send(8'h07, 1, "R4 odd 07");
    send(8'h03, 1, "R4 odd 03");
    wait_idle();

    // R5 stick parity
    set_cfg(2'd2, 1, 1, 1, 0);
    send(8'h7F, 1, "R5 stick zero");
    wait_idle();
    set_cfg(2'd2, 1, 0, 1, 0);
    send(8'h00, 1, "R5 stick one");
    wait_idle();

    // R6 two stop bits, back to back so the second stop is visible
    set_cfg(2'd3, 0, 0, 0, 1);
    send(8'h81, 1, "R6 two stop 81");
    send(8'h42, 1, "R6 two stop 42");
    wait_idle();
    set_cfg(2'd3, 0, 0, 0, 0);

    // R11 busy during a character
    send(8'h11, 1, "R11 frame");
    repeat (5 * 16) @(negedge clk);
    check("R11 busy mid-frame", 32'(tx_busy), 32'd1);
    check("R11 byte taken", 32'(tx_empty), 32'd1);
    wait_idle();
    check("R11 busy after", 32'(tx_busy), 32'd0);

    // R7 FIFO fill while transmitter disabled, overflow dropped
    @(posedge clk); #1 tx_en = 1'b0;
    for (int i = 0; i < 8; i++) send(8'(8'h20 + i), 1, "R7 fifo order");
    @(negedge clk);
    check("R7 full", 32'(tx_full), 32'd1);
    check("R7 not empty", 32'(tx_empty), 32'd0);
    send(8'hEE, 0, "R7 dropped");
    @(negedge clk);
    check("R7 still full", 32'(tx_full), 32'd1);
    check("R9 idle while tx off", 32'(txd), 32'd1);
    check("R9 not busy while tx off", 32'(tx_busy), 32'd0);
    @(posedge clk); #1 tx_en = 1'b1;
    wait_idle();

    // R8 holding mode
    @(posedge clk); #1 fifo_en = 1'b0; tx_en = 1'b0;
    send(8'h5C, 1, "R8 held byte");
    @(negedge clk);
    check("R8 full after one", 32'(tx_full), 32'd1);
    check("R8 not empty", 32'(tx_empty), 32'd0);
    send(8'hC5, 0, "R8 dropped");
    @(posedge clk); #1 tx_en = 1'b1;
    wait_idle();
    @(posedge clk); #1 fifo_en = 1'b1;

    // R9 port enable gate
    @(posedge clk); #1 line_en = 1'b0;
    send(8'h5A, 1, "R9 after line enable");
    repeat (4 * 16) @(negedge clk);
    check("R9 line off busy", 32'(tx_busy), 32'd0);
    check("R9 line off queued", 32'(tx_empty), 32'd0);
    @(posedge clk); #1 line_en = 1'b1;
    wait_idle();

    // R9 clear-to-send flow control
    @(posedge clk); #1 cts_flow_en = 1'b1; cts_n = 1'b1;
    send(8'h99, 1, "R9 after cts");
    repeat (4 * 16) @(negedge clk);
    check("R9 cts high busy", 32'(tx_busy), 32'd0);
    check("R9 cts high txd", 32'(txd), 32'd1);
    check("R9 cts high queued", 32'(tx_empty), 32'd0);
    @(posedge clk); #1 cts_n = 1'b0;
    wait_idle();
    @(posedge clk); #1 cts_flow_en = 1'b0; cts_n = 1'b1;

    // R10 break from idle
    @(posedge clk); #1 brk_en = 1'b1;
    @(negedge clk);
    check("R10 idle break low", 32'(txd), 32'd0);
    send(8'h77, 1, "R10 after break");
    repeat (4 * 16) @(negedge clk);
    check("R10 held during break", 32'(tx_empty), 32'd0);
    check("R10 not busy", 32'(tx_busy), 32'd0);
    check("R10 still low", 32'(txd), 32'd0);
    @(posedge clk); #1 brk_en = 1'b0;
    wait_idle();
    // R10 break raised mid-character: character completes, then low
    send(8'h0F, 1, "R10 frame before break");
    @(negedge clk);
    while (!tx_busy) @(negedge clk);
    @(posedge clk); #1 brk_en = 1'b1;
    @(negedge clk);
    while (tx_busy) @(negedge clk);
    @(negedge clk);
    check("R10 low after frame", 32'(txd), 32'd0);
    @(posedge clk); #1 brk_en = 1'b0;
    repeat (2 * bitc) @(negedge clk);

    // R2 integer divisor: bit = 48 cycles
    @(posedge clk); #1 div_int = 16'd3; div_frac = 6'd0;
    bitc = 48;
    send(8'h01, 1, "R2 int3 frame");
    @(negedge clk);
    while (txd) @(negedge clk);
    cnt = 0;
    while (!txd) begin
      cnt++;
      @(negedge clk);
    end
    check("R2 start bit int3", 32'(cnt), 32'd48);
    wait_idle();
    // R2 fractional divisor: 2.5 cycles per tick, bit = 40 cycles
    @(posedge clk); #1 div_int = 16'd2; div_frac = 6'd32;
    bitc = 40;
    send(8'h01, 1, "R2 frac frame");
    @(negedge clk);
    while (txd) @(negedge clk);
    cnt = 0;
    while (!txd) begin
      cnt++;
      @(negedge clk);
    end
    check("R2 start bit frac", 32'(cnt), 32'd40);
    wait_idle();

    check("R7 all frames seen", 32'(exp_bits.size()), 32'd0);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule